// File: doc/BRIEF.md
# Character-Row Vertical Timing Generator

This block is the vertical half of a character-based display controller. A horizontal timing section supplies one strobe per scanline. On each strobe the block advances a scanline counter inside the current character row and a row counter inside the frame. After the last row it can insert a programmable number of extra adjust scanlines. From these counters it drives a vertical display enable, a vertical sync pulse of fixed width, and a frame-start marker.

Five timing values are programmed through a small address/data write port: the last row index, the adjust line count, the number of visible rows, the row on which sync begins, and the last scanline index within a row. Writes go into a pending copy. That copy becomes active only when the frame wraps, so a frame never runs on a mix of old and new settings. Sync begins only on an exact row match. A sync row placed past the last row therefore gives frames with no sync at all, and the visible-row count may cover every row of the frame.

Top module: `vt_timing_gen`

## Requirements
- R1: With total register value N (select 0), a frame has N+1 character rows, numbered 0 to N. The frame length in scanlines is (N+1)*(M+1)+A, where M is the max scanline value and A is the adjust value.
- R2: A max scanline value (select 4) of 0 makes every character row exactly one scanline tall.
- R3: `vde` is high on every scanline of rows 0 up to one less than the shown value (select 2), and low on all other rows and on all adjust lines. A shown value of total+1 makes every row visible, and 0 makes none visible.
- R4: `vsync` rises on the first scanline of the row whose index equals the sync position (select 3). A sync position of 0 starts the pulse on the first scanline of the frame.
- R5: A sync position greater than the total value starts no sync pulse in that frame.
- R6: Each sync pulse lasts exactly 16 scanlines and continues counting into the next frame if the current frame ends first.
- R7: The adjust value (select 1) appends that many scanlines after the last row, and a value of 0 appends none.
- R8: `frame_start` is high for exactly one scanline per frame, the scanline on which both counters are zero.
- R9: A write with `reg_we` high stores bits 6:0 of `reg_wdata` (bits 4:0 for select 4) into the pending copy of the register. The frame in progress is not affected, and the value governs timing from the next frame start.
- R10: Writes to selects 5 through 15 change no timing.
- R11: No output changes on any clock cycle in which `line_stb` is low.
- R12: Synchronous reset loads the default register set (total 31, adjust 6, shown 25, sync row 28, max scanline 7) and zeroes the counters. Outputs then show the first scanline of a frame: `frame_start` and `vde` high, `vsync` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle strobe marking the end of a scanline |
| reg_sel | input | 4 | Register select for writes |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write enable |
| vde | output | 1 | Vertical display enable for the current scanline |
| vsync | output | 1 | Vertical sync for the current scanline |
| frame_start | output | 1 | High on the first scanline of a frame |

## Verification
The frame sequencer is run under six register sets. Each set pairs a partial, full or empty visible area with zero or non-zero adjust lines, and with one- or multi-line rows. Across the sets, the sync row is placed inside the frame, at row 0, or past the last row, and one case makes the sync pulse spill across the frame wrap. For each set the bench measures frame length, visible-line count, sync rise position and sync width on the second frame after programming, so a fault in row counting, adjust handling, enable comparison or the sync counter shows up in a different figure. Further directed runs change the total mid-frame, write to unused selects, hold the strobe low, and reset the block mid-run.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int ROW_W  = 7;
  localparam int LINE_W = 5;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_TOTAL   = 4'd0,
    SEL_ADJUST  = 4'd1,
    SEL_SHOWN   = 4'd2,
    SEL_SYNCPOS = 4'd3,
    SEL_LINEMAX = 4'd4
  } vt_sel_e;

  typedef struct packed {
    logic [ROW_W-1:0]  total;
    logic [ROW_W-1:0]  adjust;
    logic [ROW_W-1:0]  shown;
    logic [ROW_W-1:0]  syncpos;
    logic [LINE_W-1:0] linemax;
  } vt_regs_t;
endpackage

// File: rtl/vt_regfile.sv
module vt_regfile
  import vtg_pkg::*;
#(
  parameter vt_regs_t RST_REGS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load,
  output vt_regs_t          act,
  output vt_regs_t          pend
);
  vt_regs_t shadow;
  logic     unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:ROW_W];

  // pending copy, written at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= RST_REGS;
    end else if (we) begin
      case (sel)
        SEL_TOTAL:   shadow.total   <= wdata[ROW_W-1:0];
        SEL_ADJUST:  shadow.adjust  <= wdata[ROW_W-1:0];
        SEL_SHOWN:   shadow.shown   <= wdata[ROW_W-1:0];
        SEL_SYNCPOS: shadow.syncpos <= wdata[ROW_W-1:0];
        SEL_LINEMAX: shadow.linemax <= wdata[LINE_W-1:0];
        default:     shadow         <= shadow;
      endcase
    end
  end

  // active copy, refreshed only at the frame wrap
  always_ff @(posedge clk) begin
    if (rst)       act <= RST_REGS;
    else if (load) act <= shadow;
  end

  // values that govern the scanline about to begin
  assign pend = load ? shadow : act;
endmodule

// File: rtl/vt_counter.sv
module vt_counter
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [ROW_W-1:0]  total,
  input  logic [ROW_W-1:0]  adjust,
  input  logic [LINE_W-1:0] linemax,
  output logic [ROW_W-1:0]  row,
  output logic [LINE_W-1:0] line,
  output logic              in_adj,
  output logic [ROW_W-1:0]  row_n,
  output logic [LINE_W-1:0] line_n,
  output logic              adj_n,
  output logic              wrap
);
  logic [ROW_W-1:0] acnt, acnt_n;
  logic             last_line, last_row;

  assign last_line = (line == linemax);
  assign last_row  = (row == total);

  always_comb begin
    row_n  = row;
    line_n = line;
    adj_n  = in_adj;
    acnt_n = acnt;
    wrap   = 1'b0;
    if (in_adj) begin
      if (acnt + ROW_W'(1) == adjust) wrap = 1'b1;
      else                            acnt_n = acnt + ROW_W'(1);
    end else if (last_line) begin
      if (last_row) begin
        if (adjust == '0) begin
          wrap = 1'b1;
        end else begin
          adj_n  = 1'b1;
          acnt_n = '0;
          line_n = '0;
        end
      end else begin
        line_n = '0;
        row_n  = row + ROW_W'(1);
      end
    end else begin
      line_n = line + LINE_W'(1);
    end
    if (wrap) begin
      row_n  = '0;
      line_n = '0;
      adj_n  = 1'b0;
      acnt_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row    <= '0;
      line   <= '0;
      in_adj <= 1'b0;
      acnt   <= '0;
    end else if (stb) begin
      row    <= row_n;
      line   <= line_n;
      in_adj <= adj_n;
      acnt   <= acnt_n;
    end
  end
endmodule

// File: rtl/vt_outputs.sv
module vt_outputs
  import vtg_pkg::*;
#(
  parameter vt_regs_t RST_REGS = '0,
  parameter int       VS_LINES = 16,
  localparam int      VS_W     = $clog2(VS_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [ROW_W-1:0]  row_n,
  input  logic [LINE_W-1:0] line_n,
  input  logic              adj_n,
  input  logic              wrap,
  input  logic [ROW_W-1:0]  shown,
  input  logic [ROW_W-1:0]  syncpos,
  output logic              vde,
  output logic              vsync,
  output logic              frame_start
);
  localparam logic RST_SYNC = (RST_REGS.syncpos == '0);
  localparam logic RST_VDE  = (RST_REGS.shown != '0);

  logic [VS_W-1:0] vs_left, vs_next;
  logic            start_n;

  assign start_n = !adj_n && (line_n == '0) && (row_n == syncpos);

  always_comb begin
    if (start_n)              vs_next = VS_W'(VS_LINES);
    else if (vs_left != '0)   vs_next = vs_left - VS_W'(1);
    else                      vs_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_left     <= RST_SYNC ? VS_W'(VS_LINES) : '0;
      vsync       <= RST_SYNC;
      vde         <= RST_VDE;
      frame_start <= 1'b1;
    end else if (stb) begin
      vs_left     <= vs_next;
      vsync       <= (vs_next != '0);
      vde         <= !adj_n && (row_n < shown);
      frame_start <= wrap;
    end
  end
endmodule

// File: rtl/vt_timing_gen.sv
module vt_timing_gen
  import vtg_pkg::*;
#(
  parameter int RST_TOTAL   = 31,
  parameter int RST_ADJUST  = 6,
  parameter int RST_SHOWN   = 25,
  parameter int RST_SYNCPOS = 28,
  parameter int RST_LINEMAX = 7,
  parameter int VS_LINES    = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        line_stb,
  input  logic [3:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_we,
  output logic        vde,
  output logic        vsync,
  output logic        frame_start
);
  localparam vt_regs_t RST_REGS = '{
    total:   ROW_W'(RST_TOTAL),
    adjust:  ROW_W'(RST_ADJUST),
    shown:   ROW_W'(RST_SHOWN),
    syncpos: ROW_W'(RST_SYNCPOS),
    linemax: LINE_W'(RST_LINEMAX)
  };

  vt_regs_t          act_regs, pend_regs;
  logic [ROW_W-1:0]  cur_row, nxt_row;
  logic [LINE_W-1:0] cur_line, nxt_line;
  logic              cur_adj, nxt_adj, wrap, load;
  logic              unused_fields;

  assign load = line_stb && wrap;
  assign unused_fields = ^{pend_regs.total, pend_regs.adjust, pend_regs.linemax,
                           act_regs.shown, act_regs.syncpos};

  vt_regfile #(.RST_REGS(RST_REGS)) i_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .load  (load),
    .act   (act_regs),
    .pend  (pend_regs)
  );

  vt_counter i_cnt (
    .clk     (clk),
    .rst     (rst),
    .stb     (line_stb),
    .total   (act_regs.total),
    .adjust  (act_regs.adjust),
    .linemax (act_regs.linemax),
    .row     (cur_row),
    .line    (cur_line),
    .in_adj  (cur_adj),
    .row_n   (nxt_row),
    .line_n  (nxt_line),
    .adj_n   (nxt_adj),
    .wrap    (wrap)
  );

  vt_outputs #(.RST_REGS(RST_REGS), .VS_LINES(VS_LINES)) i_out (
    .clk         (clk),
    .rst         (rst),
    .stb         (line_stb),
    .row_n       (nxt_row),
    .line_n      (nxt_line),
    .adj_n       (nxt_adj),
    .wrap        (wrap),
    .shown       (pend_regs.shown),
    .syncpos     (pend_regs.syncpos),
    .vde         (vde),
    .vsync       (vsync),
    .frame_start (frame_start)
  );
endmodule

// File: rtl/vt_timing_chk.sv
module vt_timing_chk
  import vtg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              line_stb,
  input logic              vde,
  input logic              vsync,
  input logic              frame_start,
  input logic [ROW_W-1:0]  row,
  input logic [LINE_W-1:0] line,
  input logic              in_adj,
  input logic [ROW_W-1:0]  act_total,
  input logic [ROW_W-1:0]  act_syncpos
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r11_hold_without_strobe: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$past(line_stb) |-> ($stable(vde) && $stable(vsync) && $stable(frame_start)));

  a_r3_dark_in_adjust: assert property (@(posedge clk) disable iff (rst)
    in_adj |-> !vde);

  a_r4_sync_rises_on_row: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $rose(vsync) |-> (row == act_syncpos && line == '0 && !in_adj));

  a_r8_start_at_origin: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (row == '0 && line == '0 && !in_adj));

  a_r1_row_in_range: assert property (@(posedge clk) disable iff (rst)
    row <= act_total);

  a_r12_reset_marks_frame: assert property (@(posedge clk)
    rst |=> frame_start);
endmodule

bind vt_timing_gen vt_timing_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .line_stb    (line_stb),
  .vde         (vde),
  .vsync       (vsync),
  .frame_start (frame_start),
  .row         (cur_row),
  .line        (cur_line),
  .in_adj      (cur_adj),
  .act_total   (act_regs.total),
  .act_syncpos (act_regs.syncpos)
);

// File: tb/test_vt_timing_gen.sv
module test_vt_timing_gen;
  import vtg_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // total, adjust, shown, syncpos, linemax | frame len, vde lines, sync rise index, sync lines
  localparam int VEC [NVEC][9] = '{
    '{  3, 0,   2,   2, 7,  32,  16,  16, 16},
    '{  4, 3,   5,   1, 3,  23,  20,   4, 16},
    '{  9, 5,   3,  10, 1,  25,   6,  -1,  0},
    '{126, 0, 127, 127, 0, 127, 127,  -1,  0},
    '{ 19, 2,   0,   0, 0,  22,   0,   0, 16},
    '{  7, 1,   8,   5, 2,  25,  24,  15, 16}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_stb = 1'b0;
  logic [3:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic       vde, vsync, frame_start;
  logic       prev_vs = 1'b0;
  int         n_checks = 0;
  int         n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vt_timing_gen i_vt_timing_gen (
    .clk(clk), .rst(rst), .line_stb(line_stb), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_we(reg_we),
    .vde(vde), .vsync(vsync), .frame_start(frame_start)
  );

  task automatic check(input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic adv();
    prev_vs = vsync;
    @(negedge clk) line_stb = 1'b1;
    @(negedge clk) line_stb = 1'b0;
  endtask

  task automatic write_reg(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk) begin reg_we = 1'b1; reg_sel = sel; reg_wdata = d; end
    @(negedge clk) reg_we = 1'b0;
  endtask

  // walks one frame starting on its first scanline; optional total write at line wr_at
  task automatic measure(input int wr_at, input logic [7:0] wr_val,
                         output int len, output int vde_n, output int rise,
                         output int hi, output int fs_n);
    int idx = 0;
    vde_n = 0; rise = -1; hi = 0; fs_n = 0;
    do begin
      if (vde) vde_n++;
      if (vsync) hi++;
      if (frame_start) fs_n++;
      if (vsync && !prev_vs && rise < 0) rise = idx;
      if (idx == wr_at) write_reg(SEL_TOTAL, wr_val);
      adv();
      idx++;
    end while (!frame_start && idx < 3000);
    len = idx;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    prev_vs = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    int len, vn, rise, hi, fs;
    do_reset();
    // R12 reset state
    check(int'(frame_start), 1, "R12 frame_start after reset");
    check(int'(vde), 1, "R12 vde after reset");
    check(int'(vsync), 0, "R12 vsync after reset");

    // R11 no strobe, no change
    repeat (20) @(negedge clk);
    check(int'({frame_start, vde, vsync}), 3'b110, "R11 outputs held without strobe");

    // default frame, total rewritten mid-frame (R9)
    measure(10, 8'd0, len, vn, rise, hi, fs);
    check(len, 262, "R9 R1 default frame length kept after mid-frame write");
    check(vn, 200, "R3 default visible lines");
    check(rise, 224, "R4 default sync row");
    check(hi, 16, "R6 default sync width");
    check(fs, 1, "R8 one frame_start line per frame");
    measure(-1, 8'd0, len, vn, rise, hi, fs);
    check(len, 14, "R9 new total active after frame start");
    check(vn, 8, "R3 single row visible");
    check(rise, -1, "R5 sync row past total gives no sync");

    // R10 unused selects
    write_reg(4'd5, 8'd0);
    write_reg(4'd15, 8'h7F);
    measure(-1, 8'd0, len, vn, rise, hi, fs);
    measure(-1, 8'd0, len, vn, rise, hi, fs);
    check(len, 14, "R10 length unchanged by unused selects");
    check(vn, 8, "R10 visible lines unchanged by unused selects");

    // table walk: program, skip old frame and first new frame, judge the next
    for (int v = 0; v < NVEC; v++) begin
      write_reg(SEL_TOTAL,   8'(VEC[v][0]));
      write_reg(SEL_ADJUST,  8'(VEC[v][1]));
      write_reg(SEL_SHOWN,   8'(VEC[v][2]));
      write_reg(SEL_SYNCPOS, 8'(VEC[v][3]));
      write_reg(SEL_LINEMAX, 8'(VEC[v][4]));
      measure(-1, 8'd0, len, vn, rise, hi, fs);
      measure(-1, 8'd0, len, vn, rise, hi, fs);
      measure(-1, 8'd0, len, vn, rise, hi, fs);
      check(len,  VEC[v][5], $sformatf("R1 R2 R7 frame length, vector %0d", v));
      check(vn,   VEC[v][6], $sformatf("R3 visible lines, vector %0d", v));
      check(rise, VEC[v][7], $sformatf("R4 R5 sync rise index, vector %0d", v));
      check(hi,   VEC[v][8], $sformatf("R6 sync lines in frame, vector %0d", v));
    end

    // R12 reset mid-run restores defaults
    do_reset();
    check(int'({frame_start, vde, vsync}), 3'b110, "R12 outputs after second reset");
    measure(-1, 8'd0, len, vn, rise, hi, fs);
    check(len, 262, "R12 default length restored");
    check(rise, 224, "R12 default sync row restored");

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule